// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an external static RAM of 262,144 bytes that has no clock. The host offers one byte-wide read or write at a time on a valid/ready request channel. The block converts each accepted request into a strobe sequence on the memory pins. Every phase of that sequence lasts a whole number of clock cycles. The count is worked out at elaboration by rounding each nanosecond limit of the selected speed grade up against the clock period.

The request channel follows valid/ready rules. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host keeps `req_valid` and the request fields steady, and nothing is taken. The response channel has no back-pressure. Read data comes back with a single-cycle `rsp_valid` pulse, and `rsp_rdata` keeps that byte until the next read finishes.

The memory data bus is split into three signals: an outgoing byte, an enable for the block's own driver, and an incoming byte.

Top module: `sram_async_ctl`

## Requirements
- R1: Out of reset: `req_ready`=1, `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0.
- R2: On an accepted read, the address, both enables (`mem_ce_n`=0, `mem_ce`=1) and `mem_oe_n`=0 are driven from the acceptance edge for exactly T_ACC cycles, where T_ACC = max(ceil(read cycle), ceil(address access), ceil(output-enable access)). `mem_we_n` stays 1. `mem_dq_in` is captured on the last of those edges, and `rsp_valid` is high in the (T_ACC+1)-th cycle after acceptance.
- R3: `rsp_valid` is never high two cycles in a row, and `rsp_rdata` changes only in a cycle in which `rsp_valid` is high.
- R4: On an accepted write, the enables, the address and the driven data (`mem_dq_oe`=1) come up one cycle before `mem_we_n` falls. `mem_we_n` is then low for exactly T_STB = max(ceil(write pulse), ceil(data setup), ceil(enable overlap)) cycles. `mem_oe_n` stays 1 for the whole write.
- R5: While `mem_we_n` is low, both enables are asserted, `mem_dq_oe`=1, and `mem_addr` and `mem_dq_out` do not change. After the last low cycle, the enables and the data driver are held for one more cycle.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. It does not rise within T_HZ = ceil(output-float time) cycles after the read strobes are released.
- R7: After an accepted read, `req_ready` stays low for T_ACC+T_HZ cycles. After an accepted write, it stays low for max(ceil(write cycle), T_STB+2) cycles. No other request is taken in that time.
- R8: With `SLOW_GRADE`=0, the limits are: cycle 70, access 70, output enable 35, float 25, write pulse 50, data setup 30, enable overlap 60. With `SLOW_GRADE`=1 they are 100, 100, 50, 35, 60, 40, 80. At the default `CLK_NS`=4 the fast grade gives T_ACC=18, T_HZ=7, T_STB=15 and a write busy time of 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Last read byte, held |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Active-low enable |
| mem_ce | output | 1 | Active-high enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Byte driven toward memory |
| mem_dq_oe | output | 1 | Enable of the block's data driver |
| mem_dq_in | input | 8 | Byte coming from memory |

## Verification
Each result has a fixed due cycle, counted from the acceptance edge:
- A read's `rsp_valid` is due in the 19th cycle after acceptance.
- After a read, `req_ready` returns after 25 cycles.
- After a write, `req_ready` returns after 18 cycles.

The driver counts falling edges from acceptance and tests each flag at the exact count. The bench memory model supplies valid data only from the falling edge in which the strobes have been low for T_ACC cycles, so a capture that comes early reads a poison byte. The model also measures the width of every write strobe and the gap after each read against the exact cycle counts.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ACC, ST_RD_TURN, ST_WR_SETUP, ST_WR_STB, ST_WR_HOLD, ST_WR_PAD
  } seq_state_e;

  typedef enum logic [2:0] {
    TP_RC, TP_AA, TP_OE, TP_HZ, TP_WC, TP_WP, TP_CW, TP_DW
  } tparam_e;

  // nanosecond limit per speed grade
  function automatic int unsigned grade_ns(input bit slow, input tparam_e p);
    case (p)
      TP_RC:   return slow ? 100 : 70;
      TP_AA:   return slow ? 100 : 70;
      TP_OE:   return slow ? 50  : 35;
      TP_HZ:   return slow ? 35  : 25;
      TP_WC:   return slow ? 100 : 70;
      TP_WP:   return slow ? 60  : 50;
      TP_CW:   return slow ? 80  : 60;
      default: return slow ? 40  : 30;
    endcase
  endfunction

  // round up; any nonzero phase gets at least one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    if (ns == 0) return 0;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R7: a loaded phase never ends early
  p_timer_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
    end
  end

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_data_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata));
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned T_ACC  = 18,
  parameter int unsigned T_HZ   = 7,
  parameter int unsigned T_STB  = 15,
  parameter int unsigned T_PAD  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              capture,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  localparam int unsigned PAD_LD = (T_PAD == 0) ? 0 : T_PAD - 1;

  seq_state_e state_q, state_d;
  logic sel_q, oe_n_q, we_n_q, dq_oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        if (req_write) state_d = ST_WR_SETUP;
        else begin
          state_d  = ST_RD_ACC;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_ACC - 1);
        end
      end
      ST_RD_ACC: if (tmr_expired) begin
        state_d  = ST_RD_TURN;
        capture  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_HZ - 1);
      end
      ST_RD_TURN: if (tmr_expired) state_d = ST_IDLE;
      ST_WR_SETUP: begin
        state_d  = ST_WR_STB;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_STB - 1);
      end
      ST_WR_STB: if (tmr_expired) state_d = ST_WR_HOLD;
      ST_WR_HOLD: begin
        if (T_PAD == 0) state_d = ST_IDLE;
        else begin
          state_d  = ST_WR_PAD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(PAD_LD);
        end
      end
      ST_WR_PAD: if (tmr_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes come straight from flops so the memory never sees decode glitches
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= state_d inside {ST_RD_ACC, ST_WR_SETUP, ST_WR_STB, ST_WR_HOLD};
      oe_n_q  <= (state_d != ST_RD_ACC);
      we_n_q  <= (state_d != ST_WR_STB);
      dq_oe_q <= state_d inside {ST_WR_SETUP, ST_WR_STB, ST_WR_HOLD};
      if (state_q == ST_IDLE && req_valid) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign mem_addr   = addr_q;
  assign mem_ce_n   = ~sel_q;
  assign mem_ce     = sel_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = dq_oe_q;

  // checker counters
  logic [CNT_W:0] we_run_q, hz_age_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run_q <= '0;
      hz_age_q <= (CNT_W+1)'(T_HZ);
    end else begin
      we_run_q <= !we_n_q ? we_run_q + 1'b1 : '0;
      if (!oe_n_q)                           hz_age_q <= '0;
      else if (hz_age_q < (CNT_W+1)'(T_HZ))  hz_age_q <= hz_age_q + 1'b1;
    end
  end

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n_q && $past(!we_n_q)) |-> (we_run_q == (CNT_W+1)'(T_STB)));
  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  p_we_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce && mem_dq_oe));
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (hz_age_q >= (CNT_W+1)'(T_HZ)));
  p_busy_strobing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !req_ready);
endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_NS     = 4,
  parameter bit          SLOW_GRADE = 1'b0,
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned C_RC = ns_to_cyc(grade_ns(SLOW_GRADE, TP_RC), CLK_NS);
  localparam int unsigned C_AA = ns_to_cyc(grade_ns(SLOW_GRADE, TP_AA), CLK_NS);
  localparam int unsigned C_OE = ns_to_cyc(grade_ns(SLOW_GRADE, TP_OE), CLK_NS);
  localparam int unsigned C_HZ = ns_to_cyc(grade_ns(SLOW_GRADE, TP_HZ), CLK_NS);
  localparam int unsigned C_WC = ns_to_cyc(grade_ns(SLOW_GRADE, TP_WC), CLK_NS);
  localparam int unsigned C_WP = ns_to_cyc(grade_ns(SLOW_GRADE, TP_WP), CLK_NS);
  localparam int unsigned C_CW = ns_to_cyc(grade_ns(SLOW_GRADE, TP_CW), CLK_NS);
  localparam int unsigned C_DW = ns_to_cyc(grade_ns(SLOW_GRADE, TP_DW), CLK_NS);

  localparam int unsigned T_ACC = max3(C_RC, C_AA, C_OE);
  localparam int unsigned T_HZ  = (C_HZ == 0) ? 1 : C_HZ;
  localparam int unsigned T_STB = max3(C_WP, C_DW, C_CW);
  localparam int unsigned T_PAD = (C_WC > T_STB + 2) ? C_WC - T_STB - 2 : 0;
  localparam int unsigned T_MAX = max3(T_ACC, T_HZ, max3(T_STB, T_PAD, 1));
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  logic             tmr_load, tmr_expired, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  sram_ctl_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .T_ACC(T_ACC), .T_HZ(T_HZ), .T_STB(T_STB), .T_PAD(T_PAD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .capture(capture),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .dq_in(mem_dq_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // R2: data is taken only while the memory is selected and driving
  p_capture_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!mem_oe_n && mem_we_n && !mem_ce_n && mem_ce));
endmodule

// File: tb/tb_sram_async_ctl.sv
`timescale 1ns/1ps
module tb_sram_async_ctl;
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R8: fast grade at 4 ns
  localparam int E_ACC   = mx(cdiv(70, 4), cdiv(35, 4));
  localparam int E_HZ    = cdiv(25, 4);
  localparam int E_STB   = mx(mx(cdiv(50, 4), cdiv(30, 4)), cdiv(60, 4));
  localparam int E_WBUSY = mx(cdiv(70, 4), E_STB + 2);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in = 8'hEE;
  logic [17:0] mem_addr;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  sram_async_ctl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory and timing monitor
  logic [7:0] mem [int];
  int rd_age = 0, we_len = 0, gap = 100;
  logic [17:0] w_a;
  logic [7:0]  w_d;
  always @(negedge clk) begin
    bit sel, drv;
    sel = !mem_ce_n && mem_ce;
    drv = sel && !mem_oe_n && mem_we_n;
    rd_age = drv ? rd_age + 1 : 0;
    mem_dq_in <= (drv && rd_age >= E_ACC) ? (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00) : 8'hEE;
    if (drv) gap = 0; else if (gap < 100) gap++;
    if (mem_dq_oe && !mem_oe_n) chk(0, "R6 contention", 1, 0);
    if (mem_dq_oe && gap < E_HZ) chk(0, "R6 turnaround", gap, E_HZ);
    if (!mem_we_n) begin
      if (!sel || !mem_dq_oe || !mem_oe_n) chk(0, "R5 enables in strobe", {sel, mem_dq_oe}, 3);
      if (we_len == 0) begin w_a = mem_addr; w_d = mem_dq_out; end
      else if (w_a != mem_addr || w_d != mem_dq_out) chk(0, "R5 stability", mem_addr, w_a);
      we_len++;
    end else if (we_len > 0) begin
      chk(we_len == E_STB, "R4 strobe width", we_len, E_STB);
      chk(sel && mem_dq_oe, "R5 hold after strobe", {sel, mem_dq_oe}, 3);
      mem[int'(w_a)] = w_d;
      we_len = 0;
    end
  end

  // scoreboard
  logic [7:0] exp_q[$];
  logic prev_rv = 0;
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected response", rsp_rdata, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R2 read data", rsp_rdata, e);
      end
      if (prev_rv) chk(0, "R3 pulse width", 2, 1);
    end
    prev_rv = rsp_valid;
  end

  logic [7:0] ref_m [int];

  task automatic do_op(input bit wr, input logic [17:0] a, input logic [7:0] d);
    int busy, rv_at;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) ref_m[int'(a)] = d;
    else exp_q.push_back(ref_m.exists(int'(a)) ? ref_m[int'(a)] : 8'h00);
    @(negedge clk);
    req_valid = 0; req_addr = ~a;
    busy = 0; rv_at = 0;
    for (int k = 1; k < 100; k++) begin
      if (rsp_valid && rv_at == 0) rv_at = k;
      if (k == 1 && !wr) chk(!mem_oe_n && !mem_ce_n && mem_ce && mem_we_n && mem_addr == a,
                             "R2 strobes asserted", mem_oe_n, 0);
      if (k == 1 && wr) chk(mem_we_n && mem_dq_oe && !mem_ce_n && mem_oe_n,
                            "R4 setup cycle", mem_we_n, 1);
      if (req_ready) break;
      busy++;
      @(negedge clk);
    end
    if (wr) chk(busy == E_WBUSY, "R7 R8 write busy", busy, E_WBUSY);
    else begin
      chk(busy == E_ACC + E_HZ, "R7 R8 read busy", busy, E_ACC + E_HZ);
      chk(rv_at == E_ACC + 1, "R2 response cycle", rv_at, E_ACC + 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1 reset state", {req_ready, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b110110);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_we_n && !mem_dq_oe, "R1 after release", req_ready, 1);

    do_op(1, 18'h00000, 8'h00);
    do_op(1, 18'h3FFFF, 8'hFF);
    do_op(0, 18'h3FFFF, 8'h00);
    do_op(0, 18'h00000, 8'h00);
    for (int i = 0; i < 8; i++) do_op(1, 18'(32'h1000 + i * 4099), 8'($urandom_range(0, 255)));
    for (int i = 7; i >= 0; i--) do_op(0, 18'(32'h1000 + i * 4099), 8'h00);
    // read followed at once by write: turnaround (R6)
    do_op(0, 18'h3FFFF, 8'h00);
    do_op(1, 18'h12345, 8'hA5);
    // R3: a write leaves the held read byte alone
    @(negedge clk);
    chk(rsp_rdata == 8'hFF, "R3 data held across write", rsp_rdata, 8'hFF);
    do_op(0, 18'h12345, 8'h00);
    @(negedge clk);
    chk(rsp_rdata == 8'hA5, "R3 new read replaces", rsp_rdata, 8'hA5);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule